// File: doc/BRIEF.md
# Down-Counting PWM Timer Channel

This block is one timer channel that produces a pulse-width modulated output. A down counter steps once per tick. An external clock divider supplies the tick as a one-cycle enable. The output is driven by comparing the live count with an active compare value. Software can write a period buffer and a compare buffer at any time. Those writes stay in the buffers until one of two things moves them into the active counter and comparator: a manual-update control held high, or an automatic reload when the count expires.

Both buffered values are tick numbers, which means the wanted tick count minus one. A period value P gives P+1 ticks per period. A compare value C gives C+1 high ticks, capped at the full period. A compare value of all ones holds the output high for the whole period. A 0% duty cycle cannot be produced. The usual way to bring the channel up is to hold manual update for a cycle with start low, then raise start and auto-reload together. If auto-reload is cleared, the channel finishes its current period and stops. Each expiry raises a one-cycle period-done event.

Top module: `pwmt_channel`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `pwm_out` and `period_done` are low. After reset the channel is stopped: the count is zero and no compare value is armed. Raising `ctl_start` with ticks arriving produces no `period_done` and keeps `pwm_out` low until a manual update has been done.
- R2: Once armed, the counter decrements by one on each cycle where both `tick_en` and `ctl_start` are high. A period value P gives a period of exactly P+1 ticks, measured between successive `period_done` pulses. With `ctl_start` low, the count and `pwm_out` do not change.
- R3: A write through `period_wr` or `cmp_wr` changes only the buffers. The active count and compare value are unaffected until a manual update or an auto-reload.
- R4: While `ctl_manual` is high, the active count is loaded from the period buffer and the active compare value from the compare buffer, and the channel is armed. Counting is suspended and `period_done` stays low.
- R5: Before inversion, the output is high while the count is less than or equal to the active compare value and low above it. In each period there are min(C,P)+1 high ticks, so the output is high for at least one tick.
- R6: A compare value of all ones gives 100% duty. If the channel then stops because auto-reload is off, the output stays high until a manual update loads a different compare value.
- R7: When the count is zero and a tick arrives, one of two things happens. With `ctl_reload` high, the counter and comparator reload from the buffers. With `ctl_reload` low, the channel disarms and the output goes low before inversion (unless R6 applies). Either way, exactly one `period_done` pulse is produced.
- R8: `pwm_out` is the compare result XOR `ctl_invert`. Both the compare result and the inversion are registered, so `pwm_out` reflects the count and `ctl_invert` of the previous cycle.
- R9: `period_done` is high for one cycle, in the cycle after a tick taken at count zero. It is never high unless that tick was taken with `ctl_start` high and `ctl_manual` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Count enable from the external divider |
| ctl_start | input | 1 | Allows counting |
| ctl_manual | input | 1 | Manual update: copy the buffers into the active registers while high |
| ctl_reload | input | 1 | Auto-reload at expiry |
| ctl_invert | input | 1 | Output inversion |
| period_wr | input | 1 | Write strobe for the period buffer |
| period_wdata | input | CNT_W | Period tick number |
| cmp_wr | input | 1 | Write strobe for the compare buffer |
| cmp_wdata | input | CNT_W | Compare tick number |
| pwm_out | output | 1 | Registered PWM output |
| period_done | output | 1 | One-cycle end-of-period event |

## Verification
The bench builds the channel with CNT_W set to 8. With that width the all-ones compare value is 255, so both the 100% duty case and the compare-greater-than-period case can be reached with short periods. Small period values, including zero, keep each measured period down to a few dozen cycles. Running the same table entries with tick dividers of 1, 2 and 3 shows that period and duty scale with the tick rate rather than with the clock.

// File: rtl/pwmt_pkg.sv
package pwmt_pkg;

  // Source of a transfer from the buffers into the active registers
  typedef enum logic [1:0] {
    LD_NONE   = 2'd0,
    LD_MANUAL = 2'd1,
    LD_RELOAD = 2'd2
  } load_e;

endpackage

// File: rtl/pwmt_buffers.sv
module pwmt_buffers
  import pwmt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             period_wr,
  input  logic [CNT_W-1:0] period_wdata,
  input  logic             cmp_wr,
  input  logic [CNT_W-1:0] cmp_wdata,
  input  load_e            load_i,
  output logic [CNT_W-1:0] period_buf_o,
  output logic [CNT_W-1:0] act_cmp_o
);

  logic [CNT_W-1:0] period_buf_q;
  logic [CNT_W-1:0] cmp_buf_q;
  logic [CNT_W-1:0] act_cmp_q;
  logic             take_cmp;

  assign take_cmp = (load_i != LD_NONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      period_buf_q <= '0;
      cmp_buf_q    <= '0;
      act_cmp_q    <= '0;
    end else begin
      if (period_wr) period_buf_q <= period_wdata;
      if (cmp_wr)    cmp_buf_q    <= cmp_wdata;
      // The comparator takes the buffer value as it stood before any
      // write made in the same cycle.
      if (take_cmp)  act_cmp_q    <= cmp_buf_q;
    end
  end

  assign period_buf_o = period_buf_q;
  assign act_cmp_o    = act_cmp_q;

endmodule

// File: rtl/pwmt_downcount.sv
module pwmt_downcount
  import pwmt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_en,
  input  logic             ctl_start,
  input  logic             ctl_manual,
  input  logic             ctl_reload,
  input  logic [CNT_W-1:0] period_buf_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             armed_o,
  output load_e            load_o,
  output logic             expire_o
);

  logic [CNT_W-1:0] cnt_q;
  logic             armed_q;
  logic             at_zero;
  logic             advance;
  logic             expire;

  always_comb begin
    at_zero = (cnt_q == '0);
    advance = ctl_start && tick_en && !ctl_manual && armed_q;
    expire  = advance && at_zero;
    if (ctl_manual)
      load_o = LD_MANUAL;
    else if (expire && ctl_reload)
      load_o = LD_RELOAD;
    else
      load_o = LD_NONE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else if (ctl_manual) begin
      cnt_q   <= period_buf_i;
      armed_q <= 1'b1;
    end else if (expire) begin
      if (ctl_reload) cnt_q   <= period_buf_i;
      else            armed_q <= 1'b0;
    end else if (advance) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign cnt_o    = cnt_q;
  assign armed_o  = armed_q;
  assign expire_o = expire;

endmodule

// File: rtl/pwmt_outstage.sv
module pwmt_outstage #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] act_cmp_i,
  input  logic             armed_i,
  input  logic             invert_i,
  input  logic             expire_i,
  output logic             pwm_o,
  output logic             done_o
);

  localparam logic [CNT_W-1:0] FULL_DUTY = '1;

  logic raw_level;
  logic pwm_q;
  logic done_q;

  always_comb begin
    if (armed_i)
      raw_level = (cnt_i <= act_cmp_i);
    else
      raw_level = (act_cmp_i == FULL_DUTY);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pwm_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      pwm_q  <= raw_level ^ invert_i;
      done_q <= expire_i;
    end
  end

  assign pwm_o  = pwm_q;
  assign done_o = done_q;

endmodule

// File: rtl/pwmt_channel.sv
module pwmt_channel
  import pwmt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_en,
  input  logic             ctl_start,
  input  logic             ctl_manual,
  input  logic             ctl_reload,
  input  logic             ctl_invert,
  input  logic             period_wr,
  input  logic [CNT_W-1:0] period_wdata,
  input  logic             cmp_wr,
  input  logic [CNT_W-1:0] cmp_wdata,
  output logic             pwm_out,
  output logic             period_done
);

  logic [CNT_W-1:0] period_buf;
  logic [CNT_W-1:0] act_cmp;
  logic [CNT_W-1:0] cnt;
  logic             armed;
  logic             expire;
  load_e            load_sel;

  pwmt_buffers #(.CNT_W(CNT_W)) u_buffers (
    .clk          (clk),
    .rst          (rst),
    .period_wr    (period_wr),
    .period_wdata (period_wdata),
    .cmp_wr       (cmp_wr),
    .cmp_wdata    (cmp_wdata),
    .load_i       (load_sel),
    .period_buf_o (period_buf),
    .act_cmp_o    (act_cmp)
  );

  pwmt_downcount #(.CNT_W(CNT_W)) u_count (
    .clk          (clk),
    .rst          (rst),
    .tick_en      (tick_en),
    .ctl_start    (ctl_start),
    .ctl_manual   (ctl_manual),
    .ctl_reload   (ctl_reload),
    .period_buf_i (period_buf),
    .cnt_o        (cnt),
    .armed_o      (armed),
    .load_o       (load_sel),
    .expire_o     (expire)
  );

  pwmt_outstage #(.CNT_W(CNT_W)) u_out (
    .clk       (clk),
    .rst       (rst),
    .cnt_i     (cnt),
    .act_cmp_i (act_cmp),
    .armed_i   (armed),
    .invert_i  (ctl_invert),
    .expire_i  (expire),
    .pwm_o     (pwm_out),
    .done_o    (period_done)
  );

endmodule

// File: rtl/pwmt_channel_chk.sv
module pwmt_channel_chk (
  input logic clk,
  input logic rst,
  input logic tick_en,
  input logic ctl_start,
  input logic ctl_manual,
  input logic ctl_invert,
  input logic pwm_out,
  input logic period_done
);

  // R1: first cycle after reset is quiet
  p_reset_quiet_r1: assert property (@(posedge clk)
    $past(rst) |-> (!pwm_out && !period_done));

  // R9: event only follows a counting tick
  p_done_after_tick_r9: assert property (@(posedge clk) disable iff (rst)
    period_done |-> $past(tick_en && ctl_start && !ctl_manual));

  // R4: manual update suppresses the event
  p_manual_blocks_done_r4: assert property (@(posedge clk) disable iff (rst)
    $past(ctl_manual) |-> !period_done);

  // R2: a halted channel holds its output while inversion is unchanged
  p_idle_stable_r2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(rst, 2) && !$past(ctl_start, 2) && !$past(ctl_manual, 2)
     && ($past(ctl_invert) == $past(ctl_invert, 2)))
    |-> $stable(pwm_out));

endmodule

bind pwmt_channel pwmt_channel_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .tick_en     (tick_en),
  .ctl_start   (ctl_start),
  .ctl_manual  (ctl_manual),
  .ctl_invert  (ctl_invert),
  .pwm_out     (pwm_out),
  .period_done (period_done)
);

// File: tb/pwmt_channel_tb.sv
module pwmt_channel_tb;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int W = 8;
  localparam int NVEC = 7;
  // fields: period [31:24], compare [23:16], tick divider [15:8], invert [0]
  localparam logic [31:0] VECS [NVEC] = '{
    {8'd3, 8'd1,   8'd1, 8'd0},
    {8'd5, 8'd0,   8'd1, 8'd0},
    {8'd4, 8'd4,   8'd1, 8'd0},
    {8'd2, 8'd9,   8'd2, 8'd0},
    {8'd6, 8'd2,   8'd3, 8'd1},
    {8'd0, 8'd0,   8'd1, 8'd0},
    {8'd3, 8'd255, 8'd1, 8'd0}
  };

  logic clk = 1'b0;
  logic rst, tick_en, ctl_start, ctl_manual, ctl_reload, ctl_invert;
  logic period_wr, cmp_wr;
  logic [W-1:0] period_wdata, cmp_wdata;
  logic pwm_out, period_done;

  int n_checks = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  pwmt_channel #(.CNT_W(W)) u_dut (
    .clk(clk), .rst(rst), .tick_en(tick_en), .ctl_start(ctl_start),
    .ctl_manual(ctl_manual), .ctl_reload(ctl_reload), .ctl_invert(ctl_invert),
    .period_wr(period_wr), .period_wdata(period_wdata),
    .cmp_wr(cmp_wr), .cmp_wdata(cmp_wdata),
    .pwm_out(pwm_out), .period_done(period_done)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    #2;
  endtask

  task automatic write_bufs(input int p, input int c);
    period_wr = 1'b1; period_wdata = W'(p);
    cmp_wr = 1'b1;    cmp_wdata = W'(c);
    cyc();
    period_wr = 1'b0; cmp_wr = 1'b0;
  endtask

  task automatic manual_pulse();
    ctl_manual = 1'b1;
    cyc();
    ctl_manual = 1'b0;
  endtask

  // measure one full period between two period_done pulses
  task automatic run_vec(input int p, input int c, input int d, input bit inv,
                         output int len, output int hi);
    int ph;
    bit seen;
    ctl_start = 1'b0; ctl_reload = 1'b0; tick_en = 1'b0; ctl_invert = inv;
    write_bufs(p, c);
    manual_pulse();
    ctl_start = 1'b1; ctl_reload = 1'b1;
    seen = 1'b0; len = 0; hi = 0; ph = 0;
    for (int i = 0; i < 3000; i++) begin
      tick_en = (ph == d - 1);
      ph = (ph == d - 1) ? 0 : ph + 1;
      cyc();
      if (period_done) begin
        if (seen) break;
        seen = 1'b1;
      end
      if (seen) begin
        len++;
        if (pwm_out) hi++;
      end
    end
    tick_en = 1'b1;
  endtask

  initial begin
    #(20ns * 150000);
    n_fail++;
    $display("FAIL R2 watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    int dones, len, hi, p, c, d, exp_len, exp_hi;
    bit inv;
    rst = 1'b1; tick_en = 1'b0; ctl_start = 1'b0; ctl_manual = 1'b0;
    ctl_reload = 1'b0; ctl_invert = 1'b0; period_wr = 1'b0; cmp_wr = 1'b0;
    period_wdata = '0; cmp_wdata = '0;
    repeat (4) cyc();
    check(!pwm_out && !period_done, "R1 reset outputs", {pwm_out, period_done}, 0);
    rst = 1'b0;
    cyc();
    check(!pwm_out && !period_done, "R1 first cycle after reset", {pwm_out, period_done}, 0);

    // R1: unarmed channel ignores start and ticks
    ctl_start = 1'b1; ctl_reload = 1'b1; tick_en = 1'b1;
    dones = 0; hi = 0;
    for (int i = 0; i < 20; i++) begin
      cyc();
      if (period_done) dones++;
      if (pwm_out) hi++;
    end
    check(dones == 0 && hi == 0, "R1 stopped until manual update", dones + hi, 0);

    // R3/R4: buffered writes versus manual update, counter halted
    ctl_start = 1'b0;
    write_bufs(5, 2);
    manual_pulse();
    cyc();
    check(pwm_out == 1'b0, "R4 manual load count 5 above compare 2", pwm_out, 0);
    cmp_wr = 1'b1; cmp_wdata = 8'd7;
    cyc();
    cmp_wr = 1'b0;
    repeat (3) cyc();
    check(pwm_out == 1'b0, "R3 compare write without update ignored", pwm_out, 0);
    manual_pulse();
    cyc();
    check(pwm_out == 1'b1, "R4 manual update applies compare 7", pwm_out, 1);

    // R2: start low halts counting
    dones = 0; hi = 0;
    for (int i = 0; i < 20; i++) begin
      cyc();
      if (period_done) dones++;
      if (pwm_out) hi++;
    end
    check(dones == 0 && hi == 20, "R2 start low halts channel", dones * 100 + hi, 20);

    // R4: manual held blocks counting
    ctl_start = 1'b1; ctl_manual = 1'b1; dones = 0;
    for (int i = 0; i < 12; i++) begin
      cyc();
      if (period_done) dones++;
    end
    ctl_manual = 1'b0;
    check(dones == 0, "R4 held manual update blocks event", dones, 0);

    // R2/R5/R8/R9: table of periods
    for (int v = 0; v < NVEC; v++) begin
      p = int'(VECS[v][31:24]); c = int'(VECS[v][23:16]);
      d = int'(VECS[v][15:8]);  inv = VECS[v][0];
      run_vec(p, c, d, inv, len, hi);
      exp_len = (p + 1) * d;
      exp_hi  = (((c < p) ? c : p) + 1) * d;
      if (inv) exp_hi = exp_len - exp_hi;
      check(len == exp_len, $sformatf("R2 R9 period length vec%0d", v), len, exp_len);
      check(hi == exp_hi, $sformatf("R5 R6 R8 high cycles vec%0d", v), hi, exp_hi);
    end

    // R6: full duty stays high after stopping (last vector has compare 255)
    ctl_reload = 1'b0;
    repeat (20) cyc();
    check(pwm_out == 1'b1, "R6 full duty holds after stop", pwm_out, 1);
    ctl_start = 1'b0;
    write_bufs(3, 0);
    manual_pulse();
    cyc();
    check(pwm_out == 1'b0, "R6 manual update releases full duty", pwm_out, 0);

    // R7: clearing auto-reload gives one final event then stop
    ctl_invert = 1'b0;
    run_vec(2, 0, 1, 1'b0, len, hi);
    // the second event of run_vec was consumed; channel now at count 2
    ctl_reload = 1'b0; dones = 0;
    for (int i = 0; i < 20; i++) begin
      cyc();
      if (period_done) dones++;
    end
    check(dones == 1, "R7 one event after auto-reload cleared", dones, 1);
    check(pwm_out == 1'b0, "R7 output low after stop", pwm_out, 0);

    // R8: inversion while stopped
    ctl_invert = 1'b1;
    cyc();
    check(pwm_out == 1'b1, "R8 invert of stopped low output", pwm_out, 1);

    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

endmodule